// File: doc/BRIEF.md
# Full-Duplex Byte SPI Master with Selectable Clock Rate

This block is the controlling end of a byte-wide, full-duplex serial link. A host places a byte on the parallel input and pulses a write strobe. The block then drives an active-low slave select and produces eight serial clock pulses. It sends the byte out most significant bit first and collects eight bits from the slave at the same time. At the end it raises a transfer-complete flag. The received byte stays in the shift register until the host pulses a read strobe. That strobe copies it into the data buffer output.

The serial clock rate comes from a 2-bit select, which divides the system clock by 2, 4, 16 or 32. An internal divided clock runs all the time. Its rising moments, called active edges here, pace every controller step, even while the SCK pin is held low. A four-state controller sequences the work: idle, setup, exchange and waiting. In setup, slave select is held high for as long as either strobe is still asserted. When a transfer starts, the divider restarts, so the first SCK rising edge comes half an SCK period after slave select falls.

Top module: `spi_rate_master`

## Requirements
- R1: While reset is asserted (rstN low, asynchronous), bufOut is 0, ssN is 1, sck is 0, mosi is 0 and doneFlag is 0.
- R2: rateSel selects the SCK period: 00 gives 2 system clock cycles, 01 gives 4, 10 gives 16 and 11 gives 32. The first SCK rising edge of a transfer comes half a period after ssN falls.
- R3: In idle, the first active edge that sees wrStb high loads parIn into the shift register. Bit 7 of parIn is the first bit sent.
- R4: After a load, ssN stays high while wrStb or rdStb is high. ssN falls at the first active edge that sees both strobes low.
- R5: Each transfer gives exactly 8 SCK rising edges while ssN is low. Data goes out MSB first on mosi, which changes only on falling SCK edges. miso is captured on rising SCK edges.
- R6: ssN returns high at the active edge after the eighth sampled bit. doneFlag rises at that same edge and stays high for exactly one SCK period.
- R7: bufOut keeps its value until, in the waiting state, an active edge sees rdStb high. bufOut then takes the received byte, first miso bit as bit 7.
- R8: sck is low whenever ssN is high.
- R9: After the buffer copy the controller is idle again and accepts a new write.
- R10: The transfer is full duplex: the slave receives the byte that the master loaded, while the master receives the slave's byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 2 | SCK divide select (00:/2, 01:/4, 10:/16, 11:/32) |
| wrStb | input | 1 | Write strobe, loads parIn in idle |
| rdStb | input | 1 | Read strobe, copies received byte to bufOut in waiting |
| parIn | input | 8 | Parallel byte to transmit |
| miso | input | 1 | Serial data from slave |
| bufOut | output | 8 | Data buffer holding the last read byte |
| sck | output | 1 | Serial clock, low while idle |
| ssN | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to slave |
| doneFlag | output | 1 | Transfer complete, one SCK period wide |

## Verification
The hardest situation to reach from the ports is the setup state held open by a strobe that is still asserted after the load. The stimulus loads a byte, then keeps the read strobe high across many active edges before releasing it. The bench then checks that slave select stayed high and the buffer did not move. A behavioural slave in the bench shifts on SCK edges and returns random bytes. This lets every rate be checked for the exact period, the first-edge latency and the flag width in system clock cycles.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_WAIT  = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic load;    // parallel load of the shift register
    logic sample;  // capture miso
    logic shift;   // advance shift register
    logic copy;    // move shift register to buffer
  } dpStrobe_t;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 4,
  parameter int DIV2 = 16,
  parameter int DIV3 = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       restart,
  output logic       phase,
  output logic       riseTick,
  output logic       fallTick
);
  localparam int CNT_W = (DIV3 / 2 > 1) ? $clog2(DIV3 / 2) : 1;

  logic [CNT_W-1:0] halfM1;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  always_comb begin
    case (rateSel)
      2'b00:   halfM1 = CNT_W'(DIV0 / 2 - 1);
      2'b01:   halfM1 = CNT_W'(DIV1 / 2 - 1);
      2'b10:   halfM1 = CNT_W'(DIV2 / 2 - 1);
      default: halfM1 = CNT_W'(DIV3 / 2 - 1);
    endcase
  end

  assign wrap     = (cnt >= halfM1);
  assign riseTick = wrap && !phase;
  assign fallTick = wrap && phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rate_ctrl.sv
module spi_rate_ctrl
  import spi_rate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      riseTick,
  input  logic      fallTick,
  input  logic      wrStb,
  input  logic      rdStb,
  output logic      restart,
  output dpStrobe_t stb,
  output logic      ssN,
  output logic      doneFlag
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W);

  ctrlState_t state;
  logic [CW-1:0] bitCnt;
  logic strobesLow;

  assign strobesLow = !wrStb && !rdStb;
  assign restart    = riseTick && (state == ST_SETUP) && strobesLow;

  always_comb begin
    stb.load   = riseTick && (state == ST_IDLE) && wrStb;
    stb.sample = riseTick && (state == ST_XFER) && (bitCnt != LAST);
    stb.shift  = fallTick && (state == ST_XFER);
    stb.copy   = riseTick && (state == ST_WAIT) && rdStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ssN      <= 1'b1;
      doneFlag <= 1'b0;
    end else if (riseTick) begin
      doneFlag <= 1'b0;
      case (state)
        ST_IDLE:  if (wrStb) state <= ST_SETUP;
        ST_SETUP: if (strobesLow) begin
          ssN    <= 1'b0;
          bitCnt <= '0;
          state  <= ST_XFER;
        end
        ST_XFER: begin
          if (bitCnt == LAST) begin
            bitCnt   <= '0;
            ssN      <= 1'b1;
            doneFlag <= 1'b1;
            state    <= ST_WAIT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default:  if (rdStb) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_rate_dp.sv
module spi_rate_dp
  import spi_rate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] parIn,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] bufOut
);
  logic [DATA_W-1:0] shiftQ;
  logic              rxBit;

  assign mosi = shiftQ[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxBit  <= 1'b0;
      bufOut <= '0;
    end else begin
      if (stb.load)        shiftQ <= parIn;
      else if (stb.shift)  shiftQ <= {shiftQ[DATA_W-2:0], rxBit};
      if (stb.sample)      rxBit  <= miso;
      if (stb.copy)        bufOut <= shiftQ;
    end
  end
endmodule

// File: rtl/spi_rate_master.sv
module spi_rate_master
  import spi_rate_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 2,
  parameter int DIV1   = 4,
  parameter int DIV2   = 16,
  parameter int DIV3   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        rateSel,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] parIn,
  input  logic              miso,
  output logic [DATA_W-1:0] bufOut,
  output logic              sck,
  output logic              ssN,
  output logic              mosi,
  output logic              doneFlag
);
  logic      phase, riseTick, fallTick, restart;
  dpStrobe_t stb;

  spi_rate_div #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_div (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .restart(restart),
    .phase(phase), .riseTick(riseTick), .fallTick(fallTick)
  );

  spi_rate_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .riseTick(riseTick), .fallTick(fallTick),
    .wrStb(wrStb), .rdStb(rdStb), .restart(restart), .stb(stb),
    .ssN(ssN), .doneFlag(doneFlag)
  );

  spi_rate_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .parIn(parIn), .miso(miso),
    .mosi(mosi), .bufOut(bufOut)
  );

  assign sck = phase && !ssN;
endmodule

// File: rtl/spi_rate_master_chk.sv
module spi_rate_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        rateSel,
  input logic              wrStb,
  input logic              rdStb,
  input logic [DATA_W-1:0] parIn,
  input logic              miso,
  input logic [DATA_W-1:0] bufOut,
  input logic              sck,
  input logic              ssN,
  input logic              mosi,
  input logic              doneFlag
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sck); // R8

  AST_FLAG_WITH_SS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $rose(ssN)); // R6

  AST_SS_WAITS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> $past(!wrStb && !rdStb)); // R4

  AST_BUF_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bufOut) |-> $past(rdStb)); // R7

  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi)); // R5

  AST_FLAG_NOT_DURING_XFER: assert property (@(posedge clk) disable iff (!rstN)
    !ssN |-> !doneFlag); // R6
endmodule

bind spi_rate_master spi_rate_master_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_spi_rate_master.sv
module tb_spi_rate_master;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] parIn = 8'h00;
  logic       miso;
  logic [7:0] bufOut;
  logic       sck, ssN, mosi, doneFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural slave and monitor state
  logic [7:0] sreg = 8'h00;
  logic [7:0] sPreload = 8'h00;
  logic [7:0] sGot = 8'h00;
  logic       cap = 1'b0;
  logic       prevSck = 1'b0, prevSs = 1'b1;
  int cyc = 0, ssFallCyc = 0, lastRise = 0, firstLat = 0;
  int xferRises = 0, gapBad = 0, idleBad = 0, curH = 1;

  assign miso = sreg[7];

  spi_rate_master dut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .wrStb(wrStb), .rdStb(rdStb),
    .parIn(parIn), .miso(miso), .bufOut(bufOut), .sck(sck), .ssN(ssN),
    .mosi(mosi), .doneFlag(doneFlag)
  );

  always #(CLK_NS / 2) clk = ~clk;

  function automatic int halfOf(input logic [1:0] r);
    case (r)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (ssN && prevSs) sreg <= sPreload;
    if (prevSs && !ssN) begin ssFallCyc = cyc; xferRises = 0; end
    if (!prevSs && ssN) sGot = sreg;
    if (!prevSck && sck) begin
      if (xferRises == 0) firstLat = cyc - ssFallCyc;
      else if (cyc - lastRise != 2 * curH) gapBad++;
      lastRise = cyc;
      xferRises++;
      cap = mosi;
    end
    if (prevSck && !sck) sreg <= {sreg[6:0], cap};
    if (ssN && sck) idleBad++;
    prevSck = sck;
    prevSs = ssN;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one transfer; holdRd keeps rdStb high in setup for that many cycles
  task automatic xfer(input logic [1:0] r, input logic [7:0] mByte,
                      input logic [7:0] sByte, input int holdRd);
    int h, gap0, w, t;
    logic [7:0] oldBuf;
    h = halfOf(r);
    @(negedge clk);
    rateSel = r; curH = h; sPreload = sByte; parIn = mByte;
    oldBuf = bufOut; gap0 = gapBad;
    wrStb = 1'b1;
    if (holdRd > 0) rdStb = 1'b1;
    repeat (4 * h + 2) @(negedge clk);
    wrStb = 1'b0;
    if (holdRd > 0) begin
      repeat (holdRd) @(negedge clk);
      check(ssN == 1'b1, "R4 ss held by strobe", ssN, 1);
      check(bufOut == oldBuf, "R7 buffer during setup", bufOut, oldBuf);
      rdStb = 1'b0;
    end
    t = 0;
    while (!doneFlag && t < 3000) begin @(negedge clk); t++; end
    check(doneFlag == 1'b1, "R6 flag seen", doneFlag, 1);
    check(ssN == 1'b1, "R6 ss high with flag", ssN, 1);
    w = 0;
    while (doneFlag && w < 100) begin @(negedge clk); w++; end
    check(w == 2 * h, "R6 flag width", w, 2 * h);
    check(xferRises == 8, "R5 edge count", xferRises, 8);
    check(firstLat == h, "R2 first edge latency", firstLat, h);
    check(gapBad == gap0, "R2 sck period", gapBad - gap0, 0);
    check(sGot == mByte, "R10 slave received", sGot, mByte);
    check(bufOut == oldBuf, "R7 buffer before read", bufOut, oldBuf);
    rdStb = 1'b1;
    repeat (4 * h + 2) @(negedge clk);
    rdStb = 1'b0;
    @(negedge clk);
    check(bufOut == sByte, "R3 R7 buffer after read", bufOut, sByte);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    check(bufOut == 8'h00, "R1 buffer", bufOut, 0);
    check(ssN == 1'b1, "R1 ss", ssN, 1);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(mosi == 1'b0, "R1 mosi", mosi, 0);
    check(doneFlag == 1'b0, "R1 flag", doneFlag, 0);
    rstN = 1'b1;
    // directed: every rate, extreme and alternating patterns
    xfer(2'b00, 8'hA5, 8'h5A, 0);
    xfer(2'b01, 8'hFF, 8'h00, 0);
    xfer(2'b10, 8'h00, 8'hFF, 0);
    xfer(2'b11, 8'h81, 8'h7E, 0);
    // setup held open by read strobe (R4)
    xfer(2'b01, 8'h3C, 8'hC3, 40);
    xfer(2'b11, 8'h96, 8'h69, 70);
    // random back-to-back transfers (R9)
    for (int i = 0; i < 12; i++) begin
      logic [1:0] r;
      logic [7:0] m, s;
      r = 2'($urandom % 4);
      m = 8'($urandom);
      s = 8'($urandom);
      xfer(r, m, s, (i % 4 == 3) ? 10 + i : 0);
    end
    check(idleBad == 0, "R8 sck while idle", idleBad, 0);
    finish_run();
  end

  initial begin
    #(CLK_NS * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule